// File: doc/BRIEF.md
# Data Eye Center and Width Calculator

After a delay sweep has found, for every byte lane, the smallest and the largest passing delay, this block turns those edges into values that can be written to hardware. Each edge code is a signed number in steps of 1/32 of a unit interval. The block scales each edge code into the register domain using a programmable span (low end, high end, mask). It then derives each lane's eye width and eye center, and checks the width against a programmable minimum. The block produces the value that is to be programmed as the lane's trained delay. For a write-direction result this is the center plus that lane's strobe offset; for a read-direction result it is the center alone.

One pulse on the start input runs the block over lanes 0 to 7, or over lanes 0 to 8 when the ECC lane is enabled. Each lane result is presented on a valid/ready output stream. The block holds the stream while ready is low: lane number and every result field stay unchanged until the lane is accepted. With ready held high, the block delivers one lane per cycle. All inputs other than `res_ready_i` must stay stable from the start pulse until `done_o`. A one-cycle done pulse follows acceptance of the last lane. The small-window and error flags and the trained-lane bitmap stay valid until the next start.

Top module: `eye_center_calc`

## Requirements
- R1: A code c is scaled as (lo + c × f) AND mask, kept to 8 bits. Here lo and hi are the span inputs, f = (hi − lo) / 32 as an integer division that truncates toward zero, and c is sign-extended, so negative codes wrap modulo 256 before the mask is applied.
- R2: The width output of a lane is the scaled value of (max code − min code), computed at 9-bit signed width. The lo and hi outputs are the scaled min and max codes.
- R3: The center output is the scaled value of floor((min code + max code + 1) / 2), so a half step rounds upward.
- R4: When any presented lane has a scaled width below `min_eye_i` (unsigned), `small_win_o` and `error_o` are both set. They remain set until the next accepted start, which clears them. A width equal to the minimum sets neither flag.
- R5: The trained output is the center when `wr_dir_i`=0. When `wr_dir_i`=1, it is (center + that lane's 8-bit write offset) modulo 256.
- R6: A run covers lanes 0..7 when `ecc_en_i`=0 and lanes 0..8 when `ecc_en_i`=1.
- R7: In `trained_map_o`, bit n is set once lane n has been presented in the current run. Bits 15..9 always read 1. An accepted start clears bits 8..0.
- R8: Lanes are presented in ascending order. While `res_valid_o`=1 and `res_ready_i`=0, the lane and all result fields hold. With ready held high, a new lane is presented every cycle.
- R9: `done_o` is high for exactly one cycle, the cycle after the last lane is accepted. In that cycle `res_valid_o` and `busy_o` are low.
- R10: After reset, `res_valid_o`, `done_o`, `busy_o`, `small_win_o` and `error_o` are 0 and `trained_map_o` is 16'hFE00.
- R11: A start pulse while a run is busy is ignored: the lane sequence and the flags carry on unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle |
| ecc_en_i | input | 1 | Include lane 8 |
| wr_dir_i | input | 1 | 1: add write strobe offset to trained value |
| scl_lo_i | input | 8 | Register value of code 0 (span low end) |
| scl_hi_i | input | 8 | Span high end |
| scl_mask_i | input | 8 | Mask applied to every scaled value |
| min_eye_i | input | 8 | Smallest acceptable scaled width |
| lo_code_i | input | 72 | Per-lane signed min edge codes, lane n at [8n+7:8n] |
| hi_code_i | input | 72 | Per-lane signed max edge codes, same packing |
| wr_ofs_i | input | 72 | Per-lane write strobe offsets, same packing |
| res_valid_o | output | 1 | Lane result valid |
| res_ready_i | input | 1 | Consumer accepts lane result |
| res_lane_o | output | 4 | Lane number of the result |
| res_lo_o | output | 8 | Scaled min edge |
| res_hi_o | output | 8 | Scaled max edge |
| res_width_o | output | 8 | Scaled eye width |
| res_center_o | output | 8 | Scaled eye center |
| res_trained_o | output | 8 | Value to program as trained delay |
| small_win_o | output | 1 | Some lane's eye was too narrow |
| error_o | output | 1 | Error flag |
| trained_map_o | output | 16 | Lanes presented in this run, upper bits set |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench uses the default build: 8-bit delays and codes and nine lanes. With that build, both the eight-lane and the nine-lane run lengths can be reached from `ecc_en_i`. The full signed code range is also reachable, including −128 and 127 edges, whose sum and difference need the ninth bit. Random spans, masks and ready patterns exercise wrap of negative codes under the mask and truncation of the scale factor. They also exercise stalls on every lane. Directed runs set a width exactly at and one below the minimum, and make the write offset overflow.

// File: rtl/eye_pkg.sv
package eye_pkg;
  localparam int DLY_W     = 8;   // register-domain delay width
  localparam int CODE_W    = 8;   // abstract edge code width
  localparam int LANES_MAX = 9;   // lanes including the ECC lane
  localparam int STEPS_UI  = 32;  // code steps per unit interval
  localparam int MAP_W     = 16;  // trained-lane bitmap width
  localparam int LANE_W    = $clog2(LANES_MAX + 1);

  typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;
endpackage

// File: rtl/eye_scaler.sv
module eye_scaler #(
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int STEPS = 32
) (
  input  logic [DW-1:0]        span_lo_i,
  input  logic [DW-1:0]        span_hi_i,
  input  logic [DW-1:0]        mask_i,
  input  logic signed [CW:0]   code_i,
  output logic [DW-1:0]        value_o
);
  localparam int PW = DW + CW + 4;
  localparam logic signed [PW-1:0] STEPS_S = PW'(STEPS);

  logic signed [PW-1:0] lo_w, hi_w, span_w, fac_w, code_w, prod_w, sum_w;

  always_comb begin
    lo_w    = $signed({{(PW-DW){1'b0}}, span_lo_i});
    hi_w    = $signed({{(PW-DW){1'b0}}, span_hi_i});
    span_w  = hi_w - lo_w;
    fac_w   = span_w / STEPS_S;
    code_w  = PW'(code_i);
    prod_w  = code_w * fac_w;
    sum_w   = lo_w + prod_w;
    value_o = sum_w[DW-1:0] & mask_i;
  end
endmodule

// File: rtl/eye_lane_mux.sv
module eye_lane_mux #(
  parameter int CW    = 8,
  parameter int DW    = 8,
  parameter int LANES = 9,
  parameter int LW    = 4
) (
  input  logic [LANES*CW-1:0] lo_bus_i,
  input  logic [LANES*CW-1:0] hi_bus_i,
  input  logic [LANES*DW-1:0] ofs_bus_i,
  input  logic [LW-1:0]       lane_i,
  output logic signed [CW-1:0] lo_o,
  output logic signed [CW-1:0] hi_o,
  output logic [DW-1:0]       ofs_o
);
  logic [CW-1:0] lo_arr  [LANES];
  logic [CW-1:0] hi_arr  [LANES];
  logic [DW-1:0] ofs_arr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign lo_arr[g]  = lo_bus_i[g*CW +: CW];
    assign hi_arr[g]  = hi_bus_i[g*CW +: CW];
    assign ofs_arr[g] = ofs_bus_i[g*DW +: DW];
  end

  always_comb begin
    lo_o  = '0;
    hi_o  = '0;
    ofs_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_i == LW'(k)) begin
        lo_o  = $signed(lo_arr[k]);
        hi_o  = $signed(hi_arr[k]);
        ofs_o = ofs_arr[k];
      end
    end
  end
endmodule

// File: rtl/eye_lane_seq.sv
module eye_lane_seq
  import eye_pkg::*;
#(
  parameter int LANES = 9,
  parameter int LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ecc_en_i,
  input  logic          hs_i,
  output logic          clear_o,
  output logic          load_o,
  output logic [LW-1:0] load_lane_o,
  output logic          fin_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam logic [LW-1:0] LAST_ECC  = LW'(LANES - 1);
  localparam logic [LW-1:0] LAST_BASE = LW'(LANES - 2);

  seq_state_e    state_q;
  logic [LW-1:0] lane_q;
  logic [LW-1:0] last_lane;
  logic          done_q;

  assign last_lane = ecc_en_i ? LAST_ECC : LAST_BASE;

  always_comb begin
    clear_o     = 1'b0;
    load_o      = 1'b0;
    fin_o       = 1'b0;
    load_lane_o = lane_q;
    if (state_q == SEQ_IDLE) begin
      if (start_i) begin
        clear_o     = 1'b1;
        load_o      = 1'b1;
        load_lane_o = '0;
      end
    end else if (hs_i) begin
      if (lane_q == last_lane) begin
        fin_o = 1'b1;
      end else begin
        load_o      = 1'b1;
        load_lane_o = lane_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      lane_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin_o;
      if (load_o) lane_q <= load_lane_o;
      if (clear_o) state_q <= SEQ_RUN;
      else if (fin_o) state_q <= SEQ_IDLE;
    end
  end

  assign busy_o = (state_q == SEQ_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/eye_result_stage.sv
module eye_result_stage #(
  parameter int DW    = 8,
  parameter int LW    = 4,
  parameter int LANES = 9,
  parameter int MW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          load_i,
  input  logic          fin_i,
  input  logic [LW-1:0] lane_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] width_i,
  input  logic [DW-1:0] center_i,
  input  logic [DW-1:0] ofs_i,
  input  logic          wr_dir_i,
  input  logic [DW-1:0] min_eye_i,
  output logic          valid_o,
  output logic [LW-1:0] lane_o,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o,
  output logic [DW-1:0] width_o,
  output logic [DW-1:0] center_o,
  output logic [DW-1:0] trained_o,
  output logic          small_o,
  output logic          err_o,
  output logic [MW-1:0] map_o
);
  localparam logic [MW-1:0] LANE_BITS = MW'((1 << LANES) - 1);
  localparam logic [MW-1:0] MAP_RST   = ~LANE_BITS;

  logic          narrow;
  logic [DW-1:0] trained_d;
  logic [MW-1:0] map_base, map_d;
  logic          small_base, err_base;

  assign narrow    = (width_i < min_eye_i);
  assign trained_d = wr_dir_i ? (center_i + ofs_i) : center_i;

  always_comb begin
    map_base   = clear_i ? MAP_RST : map_o;
    small_base = clear_i ? 1'b0 : small_o;
    err_base   = clear_i ? 1'b0 : err_o;
    map_d      = map_base;
    if (load_i) map_d = map_base | (MW'(1) << lane_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      lane_o    <= '0;
      lo_o      <= '0;
      hi_o      <= '0;
      width_o   <= '0;
      center_o  <= '0;
      trained_o <= '0;
      small_o   <= 1'b0;
      err_o     <= 1'b0;
      map_o     <= MAP_RST;
    end else begin
      map_o <= map_d;
      if (load_i) begin
        valid_o   <= 1'b1;
        lane_o    <= lane_i;
        lo_o      <= lo_i;
        hi_o      <= hi_i;
        width_o   <= width_i;
        center_o  <= center_i;
        trained_o <= trained_d;
        small_o   <= small_base | narrow;
        err_o     <= err_base | narrow;
      end else begin
        small_o <= small_base;
        err_o   <= err_base;
        if (fin_i) valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eye_center_calc.sv
module eye_center_calc
  import eye_pkg::*;
#(
  parameter int DW    = DLY_W,
  parameter int CW    = CODE_W,
  parameter int LANES = LANES_MAX,
  parameter int STEPS = STEPS_UI,
  parameter int MW    = MAP_W,
  parameter int LW    = LANE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                ecc_en_i,
  input  logic                wr_dir_i,
  input  logic [DW-1:0]       scl_lo_i,
  input  logic [DW-1:0]       scl_hi_i,
  input  logic [DW-1:0]       scl_mask_i,
  input  logic [DW-1:0]       min_eye_i,
  input  logic [LANES*CW-1:0] lo_code_i,
  input  logic [LANES*CW-1:0] hi_code_i,
  input  logic [LANES*DW-1:0] wr_ofs_i,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic [LW-1:0]       res_lane_o,
  output logic [DW-1:0]       res_lo_o,
  output logic [DW-1:0]       res_hi_o,
  output logic [DW-1:0]       res_width_o,
  output logic [DW-1:0]       res_center_o,
  output logic [DW-1:0]       res_trained_o,
  output logic                small_win_o,
  output logic                error_o,
  output logic [MW-1:0]       trained_map_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int NSCL = 4;  // lo, hi, width, center

  logic                  clear, load, fin, hs;
  logic [LW-1:0]         load_lane;
  logic signed [CW-1:0]  lo_c, hi_c;
  logic [DW-1:0]         ofs_c;
  logic signed [CW:0]    lo_x, hi_x, diff_x, sum_x, mid_x;
  logic signed [CW:0]    codes  [NSCL];
  logic [DW-1:0]         scaled [NSCL];

  assign hs = res_valid_o & res_ready_i;

  eye_lane_seq #(.LANES(LANES), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ecc_en_i(ecc_en_i),
    .hs_i(hs), .clear_o(clear), .load_o(load), .load_lane_o(load_lane),
    .fin_o(fin), .busy_o(busy_o), .done_o(done_o)
  );

  eye_lane_mux #(.CW(CW), .DW(DW), .LANES(LANES), .LW(LW)) u_mux (
    .lo_bus_i(lo_code_i), .hi_bus_i(hi_code_i), .ofs_bus_i(wr_ofs_i),
    .lane_i(load_lane), .lo_o(lo_c), .hi_o(hi_c), .ofs_o(ofs_c)
  );

  // Edge arithmetic one bit wider than the codes so sums cannot overflow.
  always_comb begin
    lo_x   = (CW+1)'(lo_c);
    hi_x   = (CW+1)'(hi_c);
    diff_x = hi_x - lo_x;
    sum_x  = lo_x + hi_x + (CW+1)'(1);
    mid_x  = sum_x >>> 1;
    codes[0] = lo_x;
    codes[1] = hi_x;
    codes[2] = diff_x;
    codes[3] = mid_x;
  end

  for (genvar g = 0; g < NSCL; g++) begin : g_scale
    eye_scaler #(.DW(DW), .CW(CW), .STEPS(STEPS)) u_scl (
      .span_lo_i(scl_lo_i), .span_hi_i(scl_hi_i), .mask_i(scl_mask_i),
      .code_i(codes[g]), .value_o(scaled[g])
    );
  end

  eye_result_stage #(.DW(DW), .LW(LW), .LANES(LANES), .MW(MW)) u_res (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .load_i(load), .fin_i(fin),
    .lane_i(load_lane), .lo_i(scaled[0]), .hi_i(scaled[1]),
    .width_i(scaled[2]), .center_i(scaled[3]), .ofs_i(ofs_c),
    .wr_dir_i(wr_dir_i), .min_eye_i(min_eye_i),
    .valid_o(res_valid_o), .lane_o(res_lane_o), .lo_o(res_lo_o),
    .hi_o(res_hi_o), .width_o(res_width_o), .center_o(res_center_o),
    .trained_o(res_trained_o), .small_o(small_win_o), .err_o(error_o),
    .map_o(trained_map_o)
  );
endmodule

// File: rtl/eye_center_calc_chk.sv
module eye_center_calc_chk #(
  parameter int DW    = 8,
  parameter int LANES = 9,
  parameter int MW    = 16,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ecc_en_i,
  input logic [DW-1:0] min_eye_i,
  input logic          res_valid_o,
  input logic          res_ready_i,
  input logic [LW-1:0] res_lane_o,
  input logic [DW-1:0] res_width_o,
  input logic [DW-1:0] res_center_o,
  input logic          small_win_o,
  input logic          error_o,
  input logic [MW-1:0] trained_map_o,
  input logic          busy_o,
  input logic          done_o
);
  localparam logic [LW-1:0] LAST_ECC  = LW'(LANES - 1);
  localparam logic [LW-1:0] LAST_BASE = LW'(LANES - 2);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_lane_o) && $stable(res_center_o));

  p_done_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !res_valid_o && !busy_o && $past(res_valid_o && res_ready_i));

  p_lane_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> res_lane_o <= (ecc_en_i ? LAST_ECC : LAST_BASE));

  p_small_implies_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    small_win_o |-> error_o);

  p_narrow_flagged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && (res_width_o < min_eye_i) |-> small_win_o);

  p_upper_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    &trained_map_o[MW-1:LANES]);

  p_lane_marked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> trained_map_o[res_lane_o]);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind eye_center_calc eye_center_calc_chk #(.DW(DW), .LANES(LANES), .MW(MW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ecc_en_i(ecc_en_i), .min_eye_i(min_eye_i),
  .res_valid_o(res_valid_o), .res_ready_i(res_ready_i), .res_lane_o(res_lane_o),
  .res_width_o(res_width_o), .res_center_o(res_center_o),
  .small_win_o(small_win_o), .error_o(error_o), .trained_map_o(trained_map_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sim_eye_center_calc.sv
module sim_eye_center_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, ecc_en_i = 1'b0, wr_dir_i = 1'b0;
  logic [7:0]  scl_lo_i = '0, scl_hi_i = '0, scl_mask_i = '0, min_eye_i = '0;
  logic [71:0] lo_code_i = '0, hi_code_i = '0, wr_ofs_i = '0;
  logic        res_ready_i = 1'b0;
  logic        res_valid_o, small_win_o, error_o, busy_o, done_o;
  logic [3:0]  res_lane_o;
  logic [7:0]  res_lo_o, res_hi_o, res_width_o, res_center_o, res_trained_o;
  logic [15:0] trained_map_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  eye_center_calc u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int scl(input int code);
    int f, s;
    f = (int'(scl_hi_i) - int'(scl_lo_i)) / 32;
    s = int'(scl_lo_i) + code * f;
    return (s & 255) & int'(scl_mask_i);
  endfunction

  function automatic int lo_of(input int n);
    return int'($signed(lo_code_i[n*8 +: 8]));
  endfunction
  function automatic int hi_of(input int n);
    return int'($signed(hi_code_i[n*8 +: 8]));
  endfunction

  task automatic run(input bit stall, input bit poke_start);
    int last, exp_lane, emap;
    bit esmall;
    bit r;
    last = ecc_en_i ? 8 : 7;
    exp_lane = 0; emap = 16'hFE00; esmall = 0;
    @(negedge clk); start_i = 1'b1; res_ready_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    forever begin
      int a, b, w, c, t;
      a = lo_of(exp_lane); b = hi_of(exp_lane);
      w = scl(b - a); c = scl((a + b + 1) >>> 1);
      t = wr_dir_i ? ((c + int'(wr_ofs_i[exp_lane*8 +: 8])) & 255) : c;
      if (w < int'(min_eye_i)) esmall = 1;
      emap = emap | (1 << exp_lane);
      chk("R8 valid", int'(res_valid_o), 1);
      chk("R8 lane order", int'(res_lane_o), exp_lane);
      chk("R1 lo", int'(res_lo_o), scl(a));
      chk("R2 hi", int'(res_hi_o), scl(b));
      chk("R2 width", int'(res_width_o), w);
      chk("R3 center", int'(res_center_o), c);
      chk("R5 trained", int'(res_trained_o), t);
      chk("R4 small", int'(small_win_o), int'(esmall));
      chk("R7 map", int'(trained_map_o), emap);
      r = stall ? ($urandom % 3 != 0) : 1'b1;
      res_ready_i = r;
      if (poke_start && exp_lane == 2) start_i = 1'b1;  // R11 ignored while busy
      @(negedge clk); start_i = 1'b0;
      if (r && exp_lane == last) break;
      if (r) exp_lane++;
    end
    res_ready_i = 1'b0;
    chk("R9 done", int'(done_o), 1);
    chk("R9 valid low", int'(res_valid_o), 0);
    chk("R9 busy low", int'(busy_o), 0);
    chk("R6 lanes covered", int'(trained_map_o), ecc_en_i ? 16'hFFFF : 16'hFEFF);
    chk("R4 error", int'(error_o), int'(esmall));
    @(negedge clk);
    chk("R9 single pulse", int'(done_o), 0);
    chk("R11 idle after run", int'(busy_o), 0);
  endtask

  task automatic set_lane(input int n, input int a, input int b, input int o);
    lo_code_i[n*8 +: 8] = 8'(a);
    hi_code_i[n*8 +: 8] = 8'(b);
    wr_ofs_i[n*8 +: 8]  = 8'(o);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 valid", int'(res_valid_o), 0);
    chk("R10 done", int'(done_o), 0);
    chk("R10 busy", int'(busy_o), 0);
    chk("R10 flags", int'({small_win_o, error_o}), 0);
    chk("R10 map", int'(trained_map_o), 16'hFE00);

    // Directed: full code range, equal-width boundary (R4), write offset wrap (R5)
    scl_lo_i = 8'h10; scl_hi_i = 8'h50; scl_mask_i = 8'hFF; min_eye_i = 8'h00;
    ecc_en_i = 1'b1; wr_dir_i = 1'b1;
    for (int n = 0; n < 9; n++) set_lane(n, -4 + n, 10 + n, 8'hF0 + n);
    set_lane(0, -128, 127, 8'hFF);
    set_lane(1, 5, 6, 8'h80);
    run(1'b0, 1'b0);
    // width of lane 1 is scl(1) = 0x12: equal minimum, no flag
    min_eye_i = 8'h12; wr_dir_i = 1'b0;
    for (int n = 0; n < 9; n++) set_lane(n, 0, 30, 0);
    set_lane(1, 5, 6, 0);
    run(1'b1, 1'b1);
    // one above width: flag must rise, ECC lane off (R6)
    min_eye_i = 8'h13; ecc_en_i = 1'b0;
    run(1'b1, 1'b0);
    // next start clears flags (R4) when all widths large
    min_eye_i = 8'h00;
    run(1'b0, 1'b0);

    // Constrained random
    for (int k = 0; k < 40; k++) begin
      int lo, hi;
      lo = $urandom % 128; hi = lo + ($urandom % 128);
      scl_lo_i = 8'(lo); scl_hi_i = 8'(hi);
      scl_mask_i = ($urandom % 2) ? 8'hFF : 8'(($urandom % 256) | 8'h0F);
      min_eye_i = 8'($urandom % 64);
      ecc_en_i = 1'($urandom % 2); wr_dir_i = 1'($urandom % 2);
      for (int n = 0; n < 9; n++) begin
        int a;
        a = int'($urandom % 256) - 128;
        set_lane(n, a, a + int'($urandom % 40) - 4 > 127 ? 127 : a + int'($urandom % 40) - 4,
                 int'($urandom % 256));
      end
      run(1'b1, k % 5 == 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule